// File: doc/BRIEF.md
# Static Mesh Router Tile with Local Delivery Filter

This block is one router tile of a two-dimensional mesh of processing elements. It has five ports: north, south, east and west links to the neighbouring tiles, and a local port to the tile's own core. Each port has an input side and an output side, and both use a valid/ready handshake. A word is one data field plus a colour tag. The colour works as a virtual channel. There is no header and no destination address. Instead, a table that is loaded in advance gives, for each pair of colour and input port, the set of output ports that receive the word. With this one table the tile can forward point to point, send a word back to its own core, or pass a row or column broadcast onward while also keeping a copy.

Each colour has its own counter window that gates the copy sent to the core. A word bound for the local output is delivered only while its colour's counter, taken modulo a programmed period, is below a programmed length. This supports all-to-all exchange by broadcast and filter. Every input port has a two-entry queue, so a word crosses one hop per clock cycle when the path is clear. When several inputs want the same output, a rotating priority decides which input goes first.

A two-state control machine guards configuration. The tile is in IDLE when every input queue is empty. It moves to FLOW when a word is accepted. It returns from FLOW to IDLE when all queues are empty and no word arrives in that cycle. Table and filter writes take effect only in IDLE.

Top module: `mesh_route_tile`

## Requirements
- R1: After reset, no output is valid, every input is ready and the configuration port is ready. Every route set is empty. Every filter has period 0 and the largest length, so its window is open.
- R2: A word accepted at a clock edge, with its outputs ready, is presented on its output ports in the very next cycle, with data and colour unchanged.
- R3: A stream of words on one input, sent in consecutive cycles to a ready output, is accepted every cycle and leaves at one word per cycle.
- R4: The outputs of a word come from the route entry for its colour and its input port. Port indices are north 0, south 1, east 2, west 3, local 4, and bit i of a route mask selects output port i. Words from one input to one output keep their order.
- R5: A word with several selected outputs is sent only when all of them are ready, and then all copies go out in the same cycle.
- R6: A word whose route mask is empty is accepted and discarded.
- R7: When two inputs stream words to the same output, their words leave in alternating order.
- R8: A filter write (cfg_kind 1, cfg_wdata[FW-1:0] period, cfg_wdata[2*FW-1:FW] length) clears its colour's counter. Each local-bound word of that colour advances the counter. The counter wraps to 0 when it reaches the period, and a period of 0 keeps it at 0. The local copy is delivered only while the counter is below the length.
- R9: An output is valid only in a cycle in which its ready is high. At most one local-bound word leaves the input queues per cycle.
- R10: cfg_ready is high exactly in IDLE. Accepting a word moves the tile to FLOW. A route write (cfg_kind 0, mask in cfg_wdata[4:0]) made while cfg_ready is low has no effect.
- R11: In a cycle of IDLE with cfg_we high, no input is ready.
- R12: A word from the local input whose route selects the local output returns to the core in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 5 | Word offered on each input port |
| in_ready | output | 5 | Input port can take a word |
| in_data | input | 5*DW | Data of each input port, port i at bits i*DW |
| in_colour | input | 5*CW | Colour tag of each input port |
| out_valid | output | 5 | Word presented on each output port |
| out_ready | input | 5 | Receiver of each output port can take a word |
| out_data | output | 5*DW | Data of each output port |
| out_colour | output | 5*CW | Colour tag of each output port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 route entry, 1 filter entry |
| cfg_colour | input | CW | Colour being written |
| cfg_port | input | 3 | Input port of a route entry |
| cfg_wdata | input | 2*FW | Route mask or filter period and length |
| cfg_ready | output | 1 | Tile is in IDLE and accepts configuration writes |

## Verification
The assertions check on every cycle the rules that hold at the ports and between the control machine and the queues. An output is never valid without its ready. At most one local-bound word leaves per cycle. IDLE means every queue is empty. A configuration write in IDLE blocks every input, and an accepted word always takes the tile out of IDLE. Only the bench scenarios can show that the right words reach the right ports in order. They also show the one-cycle hop and full throughput, that multicast copies wait for each other, that contending inputs alternate, the filter's delivery pattern, and that writes made while busy leave the routes unchanged.

// File: rtl/rtr_pkg.sv
`timescale 1ns/1ps
package rtr_pkg;
    localparam int NPORT = 5;
    localparam int PW    = 3;

    typedef enum logic [PW-1:0] {
        P_NORTH = 3'd0,
        P_SOUTH = 3'd1,
        P_EAST  = 3'd2,
        P_WEST  = 3'd3,
        P_LOCAL = 3'd4
    } port_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FLOW = 1'b1
    } tile_state_e;
endpackage

// File: rtl/rtr_fifo.sv
`timescale 1ns/1ps
module rtr_fifo #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         nonempty,
    output logic         can_push
);
    logic [W-1:0] slot [2];
    logic [1:0]   cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + {1'b0, push} - {1'b0, pop};
    end

    // head always sits in slot 0
    always_ff @(posedge clk) begin
        if (push && (cnt == 2'd0 || (pop && cnt == 2'd1))) slot[0] <= din;
        else if (pop && cnt == 2'd2)                        slot[0] <= slot[1];
        if (push && !pop && cnt == 2'd1)                    slot[1] <= din;
    end

    assign dout     = slot[0];
    assign nonempty = (cnt != 2'd0);
    assign can_push = (cnt != 2'd2);
endmodule

// File: rtl/rtr_tables.sv
`timescale 1ns/1ps
module rtr_tables import rtr_pkg::*; #(
    parameter int CW = 5,
    parameter int FW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_kind,
    input  logic [CW-1:0]         wr_colour,
    input  logic [PW-1:0]         wr_port,
    input  logic [2*FW-1:0]       wr_data,
    input  logic [NPORT*CW-1:0]   look_colour,
    output logic [NPORT*NPORT-1:0] look_mask,
    output logic [NPORT-1:0]      look_open,
    input  logic                  adv_en,
    input  logic [CW-1:0]         adv_colour
);
    localparam int NCOL = 1 << CW;

    logic [NPORT-1:0] route  [NCOL][NPORT];
    logic [FW-1:0]    period [NCOL];
    logic [FW-1:0]    winlen [NCOL];
    logic [FW-1:0]    count  [NCOL];
    logic [FW:0]      adv_next;

    assign adv_next = {1'b0, count[adv_colour]} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCOL; c++) begin
                for (int p = 0; p < NPORT; p++) route[c][p] <= '0;
                period[c] <= '0;
                winlen[c] <= '1;
                count[c]  <= '0;
            end
        end else if (wr_en) begin
            if (!wr_kind) begin
                if (int'(wr_port) < NPORT) route[wr_colour][wr_port] <= wr_data[NPORT-1:0];
            end else begin
                period[wr_colour] <= wr_data[FW-1:0];
                winlen[wr_colour] <= wr_data[2*FW-1:FW];
                count[wr_colour]  <= '0;
            end
        end else if (adv_en) begin
            count[adv_colour] <= (adv_next >= {1'b0, period[adv_colour]}) ? '0 : adv_next[FW-1:0];
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_look
        logic [CW-1:0] col;
        assign col = look_colour[i*CW +: CW];
        assign look_mask[i*NPORT +: NPORT] = route[col][i];
        assign look_open[i] = (count[col] < winlen[col]);
    end
endmodule

// File: rtl/rtr_alloc.sv
`timescale 1ns/1ps
module rtr_alloc import rtr_pkg::*; (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT-1:0]       head_valid,
    input  logic [NPORT*NPORT-1:0] head_mask,
    input  logic [NPORT-1:0]       head_open,
    input  logic [NPORT-1:0]       out_ready,
    output logic [NPORT-1:0]       fire,
    output logic [NPORT-1:0]       take,
    output logic [NPORT*PW-1:0]    grant_src,
    output logic                   adv_en,
    output logic [PW-1:0]          adv_src
);
    logic [PW-1:0] ptr;
    logic          found;
    logic [PW-1:0] first_idx;

    // claim pass in rotating priority order
    always_comb begin
        logic [NPORT-1:0] claimed;
        logic             token;
        claimed   = '0;
        token     = 1'b0;
        fire      = '0;
        grant_src = '0;
        adv_en    = 1'b0;
        adv_src   = '0;
        found     = 1'b0;
        first_idx = ptr;
        for (int k = 0; k < NPORT; k++) begin
            int               idx;
            logic [NPORT-1:0] mask;
            logic [NPORT-1:0] eff;
            idx = int'(ptr) + k;
            if (idx >= NPORT) idx = idx - NPORT;
            mask = head_mask[idx*NPORT +: NPORT];
            eff  = mask;
            if (!head_open[idx]) eff[P_LOCAL] = 1'b0;
            if (head_valid[idx] && ((eff & claimed) == '0) && ((eff & ~out_ready) == '0)
                && !(mask[P_LOCAL] && token)) begin
                fire[idx] = 1'b1;
                claimed   = claimed | eff;
                if (mask[P_LOCAL]) begin
                    token   = 1'b1;
                    adv_en  = 1'b1;
                    adv_src = PW'(idx);
                end
                for (int o = 0; o < NPORT; o++) begin
                    if (eff[o]) grant_src[o*PW +: PW] = PW'(idx);
                end
                if (!found) begin
                    found     = 1'b1;
                    first_idx = PW'(idx);
                end
            end
        end
        take = claimed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr <= '0;
        else if (found) ptr <= (first_idx == PW'(NPORT-1)) ? '0 : first_idx + 1'b1;
    end
endmodule

// File: rtl/mesh_route_tile.sv
`timescale 1ns/1ps
module mesh_route_tile import rtr_pkg::*; #(
    parameter int DW = 16,
    parameter int CW = 5,
    parameter int FW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    in_valid,
    output logic [NPORT-1:0]    in_ready,
    input  logic [NPORT*DW-1:0] in_data,
    input  logic [NPORT*CW-1:0] in_colour,
    output logic [NPORT-1:0]    out_valid,
    input  logic [NPORT-1:0]    out_ready,
    output logic [NPORT*DW-1:0] out_data,
    output logic [NPORT*CW-1:0] out_colour,
    input  logic                cfg_we,
    input  logic                cfg_kind,
    input  logic [CW-1:0]       cfg_colour,
    input  logic [PW-1:0]       cfg_port,
    input  logic [2*FW-1:0]     cfg_wdata,
    output logic                cfg_ready
);
    localparam int WW   = DW + CW;
    localparam int NSEL = 1 << PW;

    tile_state_e state, state_nxt;

    logic [NPORT-1:0]       held, can_push, fire, wants_local;
    logic [NPORT-1:0]       look_open;
    logic [NPORT*NPORT-1:0] look_mask;
    logic [NPORT*CW-1:0]    head_colour;
    logic [NPORT*PW-1:0]    grant_src;
    logic [WW-1:0]          head [NSEL];
    logic                   adv_en, any_push, gate_in, cfg_commit;
    logic [PW-1:0]          adv_src;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        rtr_fifo #(.W(WW)) q_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (in_valid[i] & in_ready[i]),
            .din      ({in_colour[i*CW +: CW], in_data[i*DW +: DW]}),
            .pop      (fire[i]),
            .dout     (head[i]),
            .nonempty (held[i]),
            .can_push (can_push[i])
        );
        assign head_colour[i*CW +: CW] = head[i][WW-1:DW];
        assign wants_local[i]          = held[i] & look_mask[i*NPORT + int'(P_LOCAL)];
        assign in_ready[i]             = can_push[i] & ~gate_in;
    end
    for (genvar u = NPORT; u < NSEL; u++) begin : g_pad
        assign head[u] = '0;
    end

    rtr_tables #(.CW(CW), .FW(FW)) tbl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_commit),
        .wr_kind     (cfg_kind),
        .wr_colour   (cfg_colour),
        .wr_port     (cfg_port),
        .wr_data     (cfg_wdata),
        .look_colour (head_colour),
        .look_mask   (look_mask),
        .look_open   (look_open),
        .adv_en      (adv_en),
        .adv_colour  (head[adv_src][WW-1:DW])
    );

    rtr_alloc alloc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (held),
        .head_mask  (look_mask),
        .head_open  (look_open),
        .out_ready  (out_ready),
        .fire       (fire),
        .take       (out_valid),
        .grant_src  (grant_src),
        .adv_en     (adv_en),
        .adv_src    (adv_src)
    );

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        logic [WW-1:0] pick;
        assign pick                   = head[grant_src[o*PW +: PW]];
        assign out_data[o*DW +: DW]   = pick[DW-1:0];
        assign out_colour[o*CW +: CW] = pick[WW-1:DW];
    end

    assign any_push = |(in_valid & in_ready);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (any_push)           state_nxt = ST_FLOW;
            ST_FLOW: if (!any_push && !(|held)) state_nxt = ST_IDLE;
            default:                         state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cfg_ready  = (state == ST_IDLE);
        gate_in    = cfg_ready & cfg_we;
        cfg_commit = cfg_ready & cfg_we;
    end
endmodule

// File: rtl/mesh_route_tile_chk.sv
`timescale 1ns/1ps
module mesh_route_tile_chk import rtr_pkg::*; (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] in_valid,
    input logic [NPORT-1:0] in_ready,
    input logic [NPORT-1:0] out_valid,
    input logic [NPORT-1:0] out_ready,
    input logic             cfg_we,
    input logic             cfg_ready,
    input logic [NPORT-1:0] fire,
    input logic [NPORT-1:0] wants_local,
    input logic [NPORT-1:0] held
);
    // R9
    valid_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & ~out_ready) == '0);
    // R9
    single_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire & wants_local));
    // R10
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |-> (held == '0));
    // R10
    leave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_valid & in_ready) != '0) |=> !cfg_ready);
    // R11
    cfg_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_ready) |-> (in_ready == '0));
endmodule

bind mesh_route_tile mesh_route_tile_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .cfg_we      (cfg_we),
    .cfg_ready   (cfg_ready),
    .fire        (fire),
    .wants_local (wants_local),
    .held        (held)
);

// File: tb/mesh_route_tile_tb.sv
`timescale 1ns/1ps
module mesh_route_tile_tb_top;
    localparam int NP = 5, DW = 16, CW = 5, FW = 4, QD = 512;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0] in_valid = '0, in_ready, out_valid, out_ready = '1;
    logic [NP*DW-1:0] in_data = '0, out_data;
    logic [NP*CW-1:0] in_colour = '0, out_colour;
    logic cfg_we = 1'b0, cfg_kind = 1'b0, cfg_ready;
    logic [CW-1:0] cfg_colour = '0;
    logic [2:0] cfg_port = '0;
    logic [2*FW-1:0] cfg_wdata = '0;

    always #10 clk = ~clk;

    mesh_route_tile #(.DW(DW), .CW(CW), .FW(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_colour(in_colour), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_colour(out_colour),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_colour(cfg_colour),
        .cfg_port(cfg_port), .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready));

    int errors = 0, checks = 0;
    bit done = 0;
    logic [NP-1:0] tbl [32][NP];
    int fper [32], flen [32], fcnt [32];
    logic [DW+CW-1:0] q [NP][NP][QD];
    int qwr [NP][NP], qrd [NP][NP];
    int got [NP], seq [NP], p_left [NP], p_col [NP];
    logic [NP-1:0] acc;
    bit rnd = 0, rr_on = 0;
    int rr_log [64], rr_n = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int fnext(int c);
        return (fcnt[c] + 1 >= fper[c]) ? 0 : fcnt[c] + 1;
    endfunction

    task automatic sample();
        for (int o = 0; o < NP; o++) begin
            if (out_valid[o] && out_ready[o]) begin
                logic [DW+CW-1:0] w;
                int s;
                w = {out_colour[o*CW +: CW], out_data[o*DW +: DW]};
                s = int'(w[DW-1:DW-3]);
                got[o]++;
                if (rr_on && o == 2 && rr_n < 64) begin rr_log[rr_n] = s; rr_n++; end
                if (s >= NP || qrd[s][o] == qwr[s][o]) chk("R4", "unexpected word on port", o, -1);
                else begin
                    chk("R4", "word content", w, q[s][o][qrd[s][o] % QD]);
                    qrd[s][o]++;
                end
            end
        end
        acc = in_valid & in_ready;
        for (int i = 0; i < NP; i++) begin
            if (acc[i]) begin
                int c;
                logic [NP-1:0] m;
                c = int'(in_colour[i*CW +: CW]);
                m = tbl[c][i];
                if (m[4]) begin
                    if (!(fcnt[c] < flen[c])) m[4] = 1'b0;
                    fcnt[c] = fnext(c);
                end
                for (int o = 0; o < NP; o++) begin
                    if (m[o]) begin
                        q[i][o][qwr[i][o] % QD] = {in_colour[i*CW +: CW], in_data[i*DW +: DW]};
                        qwr[i][o]++;
                    end
                end
            end
        end
    endtask

    task automatic tick();
        #8;
        sample();
        @(negedge clk);
    endtask

    task automatic load(input int i, input int c);
        in_valid[i] = 1'b1;
        in_colour[i*CW +: CW] = CW'(c);
        in_data[i*DW +: DW] = {3'(i), 13'(seq[i])};
        seq[i]++;
    endtask

    task automatic drive_cycle();
        for (int i = 0; i < NP; i++) begin
            if (!in_valid[i] || acc[i]) begin
                if (p_left[i] > 0 && (!rnd || ($urandom % 2) == 0)) begin
                    load(i, rnd ? 8 + int'($urandom % 8) : p_col[i]);
                    p_left[i]--;
                end else in_valid[i] = 1'b0;
            end
        end
        if (rnd) for (int o = 0; o < NP; o++) out_ready[o] = (($urandom % 4) != 0);
        tick();
    endtask

    task automatic drain();
        rnd = 0;
        for (int i = 0; i < NP; i++) p_left[i] = 0;
        out_ready = '1;
        repeat (30) drive_cycle();
    endtask

    task automatic cfg(input bit kind, input int c, input int p, input int wd);
        for (int k = 0; k < 40 && !cfg_ready; k++) tick();
        cfg_we = 1'b1; cfg_kind = kind; cfg_colour = CW'(c);
        cfg_port = 3'(p); cfg_wdata = 8'(wd);
        if (!kind) tbl[c][p] = NP'(wd);
        else begin fper[c] = wd % 16; flen[c] = wd / 16; fcnt[c] = 0; end
        tick();
        cfg_we = 1'b0;
    endtask

    initial begin
        int base, b2, b3, alt;
        void'($urandom(32'h5eed));
        for (int c = 0; c < 32; c++) begin
            for (int p = 0; p < NP; p++) tbl[c][p] = '0;
            fper[c] = 0; flen[c] = 15; fcnt[c] = 0;
        end
        for (int s = 0; s < NP; s++) begin
            got[s] = 0; seq[s] = 0; p_left[s] = 0; p_col[s] = 0;
            for (int d = 0; d < NP; d++) begin qwr[s][d] = 0; qrd[s][d] = 0; end
        end
        acc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "out_valid after reset", out_valid, 0);
        chk("R1", "in_ready after reset", in_ready, 5'h1F);
        chk("R1", "cfg_ready after reset", cfg_ready, 1);
        @(negedge clk);

        // R6 / R1: colour 0 has an empty route after reset
        base = got[0] + got[1] + got[2] + got[3] + got[4];
        load(0, 0); tick(); chk("R6", "empty-route word accepted", acc[0], 1);
        in_valid = '0; repeat (3) tick();
        chk("R6", "no output from empty route", got[0] + got[1] + got[2] + got[3] + got[4] - base, 0);

        // R2 one-cycle hop west -> east
        cfg(0, 1, 3, 5'b00100);
        load(3, 1); tick(); in_valid = '0; #1;
        chk("R2", "east valid next cycle", out_valid[2], 1);
        chk("R2", "east data", out_data[2*DW +: DW], {3'd3, 13'(seq[3] - 1)});
        tick();

        // R3 back-to-back stream
        base = got[2];
        for (int n = 0; n < 8; n++) begin
            load(3, 1); #1;
            chk("R3", "in_ready during stream", in_ready[3], 1);
            tick();
        end
        in_valid = '0;
        chk("R3", "words out after 8 cycles", got[2] - base, 7);
        tick();
        chk("R3", "words out after 9 cycles", got[2] - base, 8);

        // R12 loopback
        cfg(0, 4, 4, 5'b10000);
        load(4, 4); tick(); in_valid = '0; #1;
        chk("R12", "local valid next cycle", out_valid[4], 1);
        chk("R12", "local data", out_data[4*DW +: DW], {3'd4, 13'(seq[4] - 1)});
        tick();

        // R5 multicast waits for every selected output
        cfg(0, 2, 0, 5'b10110);
        out_ready = 5'b11101;
        load(0, 2); tick(); in_valid = '0; tick(); #1;
        chk("R5", "no copy while south stalled", out_valid, 0);
        chk("R9", "stalled port not valid", out_valid[1], 0);
        out_ready = '1; #1;
        chk("R5", "all copies together", out_valid, 5'b10110);
        tick(); drain();

        // R7 round robin between north and south to east
        cfg(0, 5, 0, 5'b00100);
        cfg(0, 5, 1, 5'b00100);
        rr_on = 1; rr_n = 0;
        p_col[0] = 5; p_col[1] = 5; p_left[0] = 6; p_left[1] = 6;
        repeat (20) drive_cycle();
        rr_on = 0;
        alt = 0;
        for (int k = 1; k < 10; k++) if (rr_log[k] != rr_log[k-1]) alt++;
        chk("R7", "alternations among 10 east words", alt, 9);
        drain();

        // R8 filter period 4 length 1 on colour 3
        cfg(0, 3, 3, 5'b10100);
        cfg(1, 3, 0, 8'h14);
        base = got[4]; b2 = got[2];
        p_col[3] = 3; p_left[3] = 8;
        drain();
        p_left[3] = 8; repeat (14) drive_cycle(); drain();
        chk("R8", "local copies with period 4 length 1", got[4] - base, 2);
        chk("R8", "east copies", got[2] - b2, 8);
        // R8 rewrite clears counter: period 3 length 2
        cfg(1, 3, 0, 8'h23);
        base = got[4];
        p_left[3] = 6; repeat (12) drive_cycle(); drain();
        chk("R8", "local copies with period 3 length 2", got[4] - base, 4);

        // R10 writes ignored while busy
        cfg(0, 6, 0, 5'b00100);
        out_ready = 5'b11011;
        load(0, 6); tick(); in_valid = '0; #1;
        chk("R10", "cfg_ready low while word held", cfg_ready, 0);
        cfg_we = 1'b1; cfg_kind = 1'b0; cfg_colour = 5'd6; cfg_port = 3'd0; cfg_wdata = 8'b01000;
        tick(); cfg_we = 1'b0;
        drain();
        chk("R10", "cfg_ready high once drained", cfg_ready, 1);
        b2 = got[2]; b3 = got[3];
        load(0, 6); tick(); in_valid = '0; drain();
        chk("R10", "route kept east", got[2] - b2, 1);
        chk("R10", "nothing on west", got[3] - b3, 0);

        // R11 write strobe in idle blocks inputs
        load(0, 7);
        cfg_we = 1'b1; cfg_kind = 1'b0; cfg_colour = 5'd7; cfg_port = 3'd0; cfg_wdata = 8'b00100;
        tbl[7][0] = 5'b00100;
        #1;
        chk("R11", "in_ready while cfg_we in idle", in_ready, 0);
        tick(); cfg_we = 1'b0;
        chk("R11", "word not taken during write", acc[0], 0);
        tick(); in_valid = '0; drain();

        // R4 constrained random traffic over colours 8..15
        for (int c = 8; c < 16; c++)
            for (int p = 0; p < NP; p++) cfg(0, c, p, int'($urandom % 32));
        rnd = 1;
        for (int i = 0; i < NP; i++) p_left[i] = 100000;
        repeat (3000) drive_cycle();
        drain();
        for (int s = 0; s < NP; s++)
            for (int d = 0; d < NP; d++)
                chk("R4", "pending copies after drain", qwr[s][d] - qrd[s][d], 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule